// File: doc/BRIEF.md
# Mode-Select Clock Divider Bank

This block sits between a bank of frequency synthesizers and the output buffers of a board clock generator. It decodes a three-bit mode code into one of six operating modes and produces seven clock groups, each with its own output enable: CPU, SDRAM, 66 MHz, PCI, 48 MHz, reference and APIC.

In the normal modes the fixed-frequency groups pass straight through from their synthesizer sources. The CPU group takes one of three sources, chosen by the code. At 100 MHz the CPU group is the inverted SDRAM source, which puts it 180 degrees away from SDRAM. In test mode a single test clock drives every group through integer dividers that restart together, so their edges stay aligned. In the off mode and in the reserved mode every enable is dropped and every clock is held low. The reserved mode also raises an error flag.

Top module: `clkbank_top`

## Requirements
- R1: Group bit positions in `grpClk` and `grpOe` are 0 CPU, 1 SDRAM, 2 66 MHz, 3 PCI, 4 48 MHz, 5 reference, 6 APIC. Code {selFast,selMode} = x00 is the off mode: all seven enables are 0, all seven clocks are 0, and `modeErr` is 0, whatever the value of `selFast`.
- R2: Code x01 is test mode: all seven enables are 1, `modeErr` is 0, and the reference group equals `testClk`.
- R3: In test mode the 48 MHz, CPU/SDRAM, 66 MHz and PCI/APIC groups divide `testClk` by 2, 4, 6 and 12 with 50 percent duty. Each group is low on entry. After k rising edges spent in test mode, a divide-by-N group equals floor(k/(N/2)) mod 2. Any code other than test mode holds every divider cleared.
- R4: In test mode the CPU and SDRAM groups are identical.
- R5: The APIC group equals the PCI group in every mode.
- R6: Code 010 enables all groups and drives CPU from `syn66`.
- R7: Code 011 enables all groups and drives CPU with the inverse of `synSdram`.
- R8: Code 111 enables all groups and drives CPU from `synCpu133`.
- R9: In codes 010, 011 and 111 the groups pass through as follows: SDRAM = `synSdram`, 66 MHz = `syn66`, PCI = `syn33`, 48 MHz = `syn48`, reference = `synRef`, APIC = `syn33`.
- R10: Code 110 is reserved: `modeErr` is 1, and all enables and all clocks are 0. `modeErr` is 0 for every other code.
- R11: While `rstN` is low, every divider output is forced low at once, without waiting for a clock edge. After release, counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| testClk | input | 1 | Test clock; drives the dividers and the reference group in test mode |
| rstN | input | 1 | Asynchronous active-low reset of the dividers |
| selFast | input | 1 | Mode code bit 2 (fast-CPU strap) |
| selMode | input | 2 | Mode code bits 1:0 |
| synCpu133 | input | 1 | 133 MHz synthesizer clock for the CPU group |
| synSdram | input | 1 | 100 MHz synthesizer clock |
| syn66 | input | 1 | 66 MHz synthesizer clock |
| syn33 | input | 1 | 33 MHz synthesizer clock for PCI and APIC |
| syn48 | input | 1 | 48 MHz synthesizer clock |
| synRef | input | 1 | Reference clock from the crystal oscillator |
| grpClk | output | 7 | Group clocks, one bit per group as ordered in R1 |
| grpOe | output | 7 | Group output enables, same bit order |
| modeErr | output | 1 | Reserved-code flag |

## Verification
The assertions sample on `testClk`. They assume the mode code and synthesizer inputs are steady across each rising edge, so that a code change is seen whole at one edge. The bench therefore changes every input only on the falling edge and checks the combinational paths a fixed delay later. The divider properties assume `testClk` keeps running in every mode, since the dividers are cleared by a clocked strobe. The bench keeps it free-running throughout.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;

  localparam int GROUPS = 7;
  localparam int G_CPU  = 0;
  localparam int G_SDR  = 1;
  localparam int G_V66  = 2;
  localparam int G_PCI  = 3;
  localparam int G_U48  = 4;
  localparam int G_REF  = 5;
  localparam int G_APIC = 6;

  typedef enum logic [1:0] {
    CPU_SRC_66,
    CPU_SRC_SDRAM_INV,
    CPU_SRC_133
  } cpuSrc_e;

  typedef enum logic [2:0] {
    MODE_OFF,
    MODE_TEST,
    MODE_CPU66,
    MODE_CPU100,
    MODE_RSVD,
    MODE_CPU133
  } mode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    oeAll;
    logic    useTest;
    logic    divClr;
    cpuSrc_e cpuSrc;
    logic    modeErr;
  } ctrlStrobe_t;

endpackage

// File: rtl/clkbank_ctrl.sv
module clkbank_ctrl
  import clkbank_pkg::*;
(
  input  logic        selFast,
  input  logic [1:0]  selMode,
  output ctrlStrobe_t strobe
);

  mode_e mode;

  // Mode decode: the low two bits pick off/test, else selFast splits the rest.
  always_comb begin
    unique case (selMode)
      2'b00:   mode = MODE_OFF;
      2'b01:   mode = MODE_TEST;
      2'b10:   mode = selFast ? MODE_RSVD   : MODE_CPU66;
      default: mode = selFast ? MODE_CPU133 : MODE_CPU100;
    endcase
  end

  always_comb begin
    strobe.oeAll   = 1'b0;
    strobe.useTest = 1'b0;
    strobe.divClr  = 1'b1;
    strobe.cpuSrc  = CPU_SRC_66;
    strobe.modeErr = 1'b0;
    unique case (mode)
      MODE_OFF: ;
      MODE_TEST: begin
        strobe.oeAll   = 1'b1;
        strobe.useTest = 1'b1;
        strobe.divClr  = 1'b0;
      end
      MODE_CPU66: begin
        strobe.oeAll  = 1'b1;
        strobe.cpuSrc = CPU_SRC_66;
      end
      MODE_CPU100: begin
        strobe.oeAll  = 1'b1;
        strobe.cpuSrc = CPU_SRC_SDRAM_INV;
      end
      MODE_CPU133: begin
        strobe.oeAll  = 1'b1;
        strobe.cpuSrc = CPU_SRC_133;
      end
      MODE_RSVD: strobe.modeErr = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/clkbank_div.sv
// Even-ratio divider with 50 percent duty, or pass-through for ratio 1.
module clkbank_div #(
  parameter int RATIO = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  output logic divOut
);

  generate
    if (RATIO == 1) begin : g_pass
      assign divOut = clk;
    end else begin : g_count
      localparam int HALF = RATIO / 2;
      localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
      localparam logic [CW-1:0] LAST = CW'(HALF - 1);

      logic [CW-1:0] cnt;
      logic          outQ;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cnt  <= '0;
          outQ <= 1'b0;
        end else if (clr) begin
          cnt  <= '0;
          outQ <= 1'b0;
        end else if (cnt == LAST) begin
          cnt  <= '0;
          outQ <= ~outQ;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end

      assign divOut = outQ;

      // R3
      half_period_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
        (!clr && cnt == LAST) |=> (outQ != $past(outQ)));
      // R3
      hold_between_toggles_chk: assert property (@(posedge clk) disable iff (!rstN)
        (!clr && cnt != LAST) |=> $stable(outQ));
      // R3
      clear_low_chk: assert property (@(posedge clk) disable iff (!rstN)
        clr |=> (!outQ && cnt == '0));
    end
  endgenerate

endmodule

// File: rtl/clkbank_datapath.sv
module clkbank_datapath
  import clkbank_pkg::*;
#(
  parameter int DIV_CPU  = 4,
  parameter int DIV_SDR  = 4,
  parameter int DIV_V66  = 6,
  parameter int DIV_PCI  = 12,
  parameter int DIV_U48  = 2,
  parameter int DIV_REF  = 1,
  parameter int DIV_APIC = 12
) (
  input  logic              testClk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              synCpu133,
  input  logic              synSdram,
  input  logic              syn66,
  input  logic              syn33,
  input  logic              syn48,
  input  logic              synRef,
  output logic [GROUPS-1:0] grpClk,
  output logic [GROUPS-1:0] grpOe
);

  localparam int RATIO [GROUPS] = '{DIV_CPU, DIV_SDR, DIV_V66, DIV_PCI,
                                    DIV_U48, DIV_REF, DIV_APIC};

  logic [GROUPS-1:0] divClk;
  logic [GROUPS-1:0] normClk;

  // One divider per group, all sharing one clear so edges stay aligned.
  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      clkbank_div #(.RATIO(RATIO[g])) u_div (
        .clk   (testClk),
        .rstN  (rstN),
        .clr   (strobe.divClr),
        .divOut(divClk[g])
      );
    end
  endgenerate

  always_comb begin
    unique case (strobe.cpuSrc)
      CPU_SRC_SDRAM_INV: normClk[G_CPU] = ~synSdram;
      CPU_SRC_133:       normClk[G_CPU] = synCpu133;
      default:           normClk[G_CPU] = syn66;
    endcase
    normClk[G_SDR]  = synSdram;
    normClk[G_V66]  = syn66;
    normClk[G_PCI]  = syn33;
    normClk[G_U48]  = syn48;
    normClk[G_REF]  = synRef;
    normClk[G_APIC] = syn33;
  end

  always_comb begin
    for (int g = 0; g < GROUPS; g++) begin
      grpClk[g] = strobe.oeAll & (strobe.useTest ? divClk[g] : normClk[g]);
    end
    grpOe = {GROUPS{strobe.oeAll}};
  end

  // R1 R10
  disabled_quiet_chk: assert property (@(posedge testClk) disable iff (!rstN)
    !strobe.oeAll |-> (grpOe == '0 && grpClk == '0));
  // R10
  reserved_off_chk: assert property (@(posedge testClk) disable iff (!rstN)
    strobe.modeErr |-> (grpOe == '0));
  // R5
  apic_follows_pci_chk: assert property (@(posedge testClk) disable iff (!rstN)
    grpClk[G_APIC] == grpClk[G_PCI]);
  // R4
  test_cpu_sdram_chk: assert property (@(posedge testClk) disable iff (!rstN)
    strobe.useTest |-> (grpClk[G_CPU] == grpClk[G_SDR]));
  // R7
  cpu100_antiphase_chk: assert property (@(posedge testClk) disable iff (!rstN)
    (strobe.oeAll && !strobe.useTest && strobe.cpuSrc == CPU_SRC_SDRAM_INV)
      |-> (grpClk[G_CPU] != grpClk[G_SDR]));
  // R3
  test_entry_low_chk: assert property (@(posedge testClk) disable iff (!rstN)
    $past(strobe.divClr) |-> (divClk[G_PCI] == 1'b0 && divClk[G_V66] == 1'b0));

endmodule

// File: rtl/clkbank_top.sv
module clkbank_top
  import clkbank_pkg::*;
#(
  parameter int DIV_CPU  = 4,
  parameter int DIV_SDR  = 4,
  parameter int DIV_V66  = 6,
  parameter int DIV_PCI  = 12,
  parameter int DIV_U48  = 2,
  parameter int DIV_REF  = 1,
  parameter int DIV_APIC = 12
) (
  input  logic              testClk,
  input  logic              rstN,
  input  logic              selFast,
  input  logic [1:0]        selMode,
  input  logic              synCpu133,
  input  logic              synSdram,
  input  logic              syn66,
  input  logic              syn33,
  input  logic              syn48,
  input  logic              synRef,
  output logic [GROUPS-1:0] grpClk,
  output logic [GROUPS-1:0] grpOe,
  output logic              modeErr
);

  ctrlStrobe_t strobe;

  clkbank_ctrl u_ctrl (
    .selFast(selFast),
    .selMode(selMode),
    .strobe (strobe)
  );

  clkbank_datapath #(
    .DIV_CPU (DIV_CPU),
    .DIV_SDR (DIV_SDR),
    .DIV_V66 (DIV_V66),
    .DIV_PCI (DIV_PCI),
    .DIV_U48 (DIV_U48),
    .DIV_REF (DIV_REF),
    .DIV_APIC(DIV_APIC)
  ) u_dp (
    .testClk  (testClk),
    .rstN     (rstN),
    .strobe   (strobe),
    .synCpu133(synCpu133),
    .synSdram (synSdram),
    .syn66    (syn66),
    .syn33    (syn33),
    .syn48    (syn48),
    .synRef   (synRef),
    .grpClk   (grpClk),
    .grpOe    (grpOe)
  );

  assign modeErr = strobe.modeErr;

endmodule

// File: tb/clkbank_top_tb.sv
module clkbank_top_tb;

  localparam int CLK_PERIOD = 10;

  logic       testClk = 1'b0;
  logic       rstN;
  logic       selFast;
  logic [1:0] selMode;
  logic [5:0] syn;   // {cpu133, sdram, v66, p33, u48, ref}
  logic [6:0] grpClk;
  logic [6:0] grpOe;
  logic       modeErr;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) testClk = ~testClk;

  clkbank_top u_dut (
    .testClk  (testClk),
    .rstN     (rstN),
    .selFast  (selFast),
    .selMode  (selMode),
    .synCpu133(syn[5]),
    .synSdram (syn[4]),
    .syn66    (syn[3]),
    .syn33    (syn[2]),
    .syn48    (syn[1]),
    .synRef   (syn[0]),
    .grpClk   (grpClk),
    .grpOe    (grpOe),
    .modeErr  (modeErr)
  );

  typedef struct packed {
    logic [2:0] code;
    logic [5:0] syn;
    logic [6:0] expClk;   // {apic, ref, u48, pci, v66, sdram, cpu}
    logic [6:0] expOe;
    logic       expErr;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 6'b111111, 7'b0000000, 7'h00, 1'b0, 4'd1},   // R1
    '{3'b100, 6'b111111, 7'b0000000, 7'h00, 1'b0, 4'd1},   // R1
    '{3'b110, 6'b111111, 7'b0000000, 7'h00, 1'b1, 4'd10},  // R10
    '{3'b010, 6'b001000, 7'b0000101, 7'h7f, 1'b0, 4'd6},   // R6
    '{3'b010, 6'b110111, 7'b1111010, 7'h7f, 1'b0, 4'd9},   // R9
    '{3'b011, 6'b010000, 7'b0000010, 7'h7f, 1'b0, 4'd7},   // R7
    '{3'b011, 6'b000000, 7'b0000001, 7'h7f, 1'b0, 4'd7},   // R7
    '{3'b111, 6'b100000, 7'b0000001, 7'h7f, 1'b0, 4'd8},   // R8
    '{3'b111, 6'b011111, 7'b1111110, 7'h7f, 1'b0, 4'd9},   // R9
    '{3'b111, 6'b000100, 7'b1001000, 7'h7f, 1'b0, 4'd5},   // R5
    '{3'b011, 6'b101010, 7'b0010101, 7'h7f, 1'b0, 4'd7}    // R7
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic expDiv(input int k, input int n);
    return logic'((k / (n / 2)) % 2);
  endfunction

  // Dividers of groups 0,1,2,3,4,6 after k edges in test mode (R3, R4, R5).
  task automatic chkDividers(input int k);
    logic [6:0] e;
    e[0] = expDiv(k, 4);
    e[1] = expDiv(k, 4);
    e[2] = expDiv(k, 6);
    e[3] = expDiv(k, 12);
    e[4] = expDiv(k, 2);
    e[5] = 1'b0;
    e[6] = expDiv(k, 12);
    chk((grpClk & 7'b1011111) == e, "R3 divided groups", int'(grpClk & 7'b1011111), int'(e));
    chk(grpClk[0] == grpClk[1], "R4 cpu equals sdram", int'(grpClk[0]), int'(grpClk[1]));
    chk(grpClk[6] == grpClk[3], "R5 apic equals pci", int'(grpClk[6]), int'(grpClk[3]));
  endtask

  task automatic runTest(input int edges);
    for (int k = 1; k <= edges; k++) begin
      @(posedge testClk);
      #1;
      chk(grpClk[5] == 1'b1, "R2 reference high", int'(grpClk[5]), 1);
      @(negedge testClk);
      #1;
      chk(grpClk[5] == 1'b0, "R2 reference low", int'(grpClk[5]), 0);
      chkDividers(k);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    selFast = 1'b0;
    selMode = 2'b01;
    syn = '0;
    repeat (3) @(posedge testClk);
    @(negedge testClk);
    #1;
    // R11: dividers low under reset even in test mode
    chk((grpClk & 7'b1011111) == 7'b0, "R11 reset state", int'(grpClk), 0);
    chk(grpOe == 7'h7f, "R2 enables in test", int'(grpOe), 'h7f);
    chk(modeErr == 1'b0, "R10 no error", int'(modeErr), 0);
    selMode = 2'b00;
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge testClk);
      {selFast, selMode} = VECS[i].code;
      syn = VECS[i].syn;
      #1;
      chk(grpClk == VECS[i].expClk, $sformatf("R%0d vec %0d clocks", VECS[i].req, i),
          int'(grpClk), int'(VECS[i].expClk));
      chk(grpOe == VECS[i].expOe, $sformatf("R%0d vec %0d enables", VECS[i].req, i),
          int'(grpOe), int'(VECS[i].expOe));
      chk(modeErr == VECS[i].expErr, $sformatf("R%0d vec %0d error flag", VECS[i].req, i),
          int'(modeErr), int'(VECS[i].expErr));
    end

    // Test mode entry: R2, R3
    @(negedge testClk);
    {selFast, selMode} = 3'b101;
    #1;
    chk(grpOe == 7'h7f, "R2 test enables", int'(grpOe), 'h7f);
    chk(modeErr == 1'b0, "R2 test no error", int'(modeErr), 0);
    chkDividers(0);
    runTest(24);

    // Asynchronous reset mid-run: R11
    rstN = 1'b0;
    #1;
    chk((grpClk & 7'b1011111) == 7'b0, "R11 async clear", int'(grpClk & 7'b1011111), 0);
    @(negedge testClk);
    rstN = 1'b1;
    #1;
    chkDividers(0);
    runTest(12);

    // Leave and re-enter test mode: R3 restart
    @(negedge testClk);
    {selFast, selMode} = 3'b011;
    repeat (3) @(negedge testClk);
    {selFast, selMode} = 3'b001;
    #1;
    chkDividers(0);
    runTest(12);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule